// File: doc/BRIEF.md
# Dual-Channel Interval Timer

This block is a bus-attached timer with two independent 16-bit channels that run off one shared clock. Each channel divides that clock by a power of two chosen by a 4-bit code. It counts upward on each divided tick until the count reaches a programmed limit. At that point it raises a sticky pending flag. In autoreload mode the channel starts again from zero. In single-run mode it halts with the count held at the limit. Each channel drives its own interrupt line, which is the pending flag qualified by an interrupt-enable bit.

Software reaches each channel through a 16-bit register window. A channel's window starts at byte address 0x80 times (channel + 1). The window holds a control word, a pending-flag word, a limit word and a read-only count word. The count is readable at any time. With a limit of 0xFFFF in autoreload mode, the count serves as a free-running time base.

Each channel is built around a two-state machine. In CH_STOPPED the counter is frozen. In CH_RUNNING it advances on divided ticks. The transitions are:
- START (CH_STOPPED to CH_RUNNING): the run bit is written to 1 while the channel is stopped.
- HALT (CH_RUNNING to CH_STOPPED): the run bit is written to 0.
- ONESHOT_DONE (CH_RUNNING to CH_STOPPED): a match occurs in single-run mode.
- WRAP (CH_RUNNING to CH_RUNNING): a match occurs in autoreload mode.

Top module: `dual_interval_timer`

## Requirements
- R1: Channel x (x = 0 or 1) decodes control at byte address 0x80+x*0x80, pending flag at +0x04, limit at +0x08 and count at +0x0C. The control and limit words read back what was written, subject to R2. Any other address reads 0, and writes to it are ignored.
- R2: The control word has interrupt enable at bit 8, run at bit 5, single-run select at bit 4 (1 = single-run, 0 = autoreload) and the divider code at bits [3:0]. All other bits read 0. Reading the run bit returns 1 exactly while the channel is in CH_RUNNING.
- R3: Divider code n from 0 to 8 produces one tick every 2^n clocks. Codes 9 to 15 produce one tick every 256 clocks. After START, the count increases by one on every tick, so k clocks after the START edge it reads floor(k/2^n) until the first match.
- R4: When a tick arrives while the count equals the limit, the pending flag sets. In autoreload mode the count returns to 0 on that tick and continues, so a match recurs every (limit+1) ticks.
- R5: In single-run mode a match clears the run bit and the count holds at the limit value.
- R6: Writing 0 to the run bit while running stops the count on that same edge. The count then holds its value.
- R7: Writing 1 to the run bit while stopped sets the count to 0 and restarts the divider. Writing 1 while already running does not restart the channel.
- R8: Bit 0 of the pending-flag word reads the flag. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R9: irq[x] is high exactly when channel x has its flag pending and its interrupt enable set.
- R10: Accesses to one channel, and its running, do not change the other channel's registers or count.
- R11: A limit written while the channel is stopped is the one used after the next START.
- R12: After reset every register of both channels reads 0 and both irq lines are low.
- R13: With limit 0xFFFF in autoreload mode, the count passes through all 65536 values and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 9 | Byte address of the accessed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
The bench targets the exact tick on which the flag appears. A design that matched one tick early or late, or that counted the START edge as a tick, would show its count and flag off by one divider period.

It sweeps divider codes past 8, where a design that failed to saturate would divide by a wrong or zero period. It also checks that a stop write freezes the count on its own edge, and that single-run mode holds the count at the limit rather than wrapping to zero.

It checks that a 0 written to the pending-flag word is harmless, that the enable bit alone gates the interrupt, and that a full 16-bit wrap returns the count to zero.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int REG_W       = 16;
    localparam int CODE_W      = 4;
    localparam int MAX_LOG_DIV = 8;

    localparam int CTRL_IE_BIT = 8;
    localparam int CTRL_RUN_BIT = 5;
    localparam int CTRL_OS_BIT = 4;

    localparam logic [6:0] OFS_CTRL  = 7'h00;
    localparam logic [6:0] OFS_FLAG  = 7'h04;
    localparam logic [6:0] OFS_LIMIT = 7'h08;
    localparam logic [6:0] OFS_COUNT = 7'h0C;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int MAX_LOG = 8,
    parameter int CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [MAX_LOG-1:0] phase_q;
    logic [MAX_LOG-1:0] mask;
    int                 eff_log;

    always_comb begin
        eff_log = (int'(code) > MAX_LOG) ? MAX_LOG : int'(code);
        for (int i = 0; i < MAX_LOG; i++) begin
            mask[i] = (i < eff_log);
        end
    end

    assign tick = run && ((phase_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import dit_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         flag_we,
    input  logic         limit_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_rd,
    output logic [W-1:0] flag_rd,
    output logic [W-1:0] limit_rd,
    output logic [W-1:0] count_rd,
    output logic         irq
);
    ch_state_e          state_q, state_d;
    logic               ie_q, os_q, flag_q;
    logic [CODE_W-1:0]  code_q;
    logic [W-1:0]       limit_q, count_q;
    logic               tick, start, halt, tick_eff, match;

    assign start    = ctrl_we && wdata[CTRL_RUN_BIT] && (state_q == CH_STOPPED);
    assign halt     = ctrl_we && !wdata[CTRL_RUN_BIT];
    assign tick_eff = tick && !halt;
    assign match    = tick_eff && (count_q == limit_q);

    tick_divider #(
        .MAX_LOG (MAX_LOG_DIV),
        .CODE_W  (CODE_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (state_q == CH_RUNNING),
        .code    (code_q),
        .tick    (tick)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (start) state_d = CH_RUNNING;
            CH_RUNNING: begin
                if (halt)                          state_d = CH_STOPPED;
                else if (match && os_q && !ctrl_we) state_d = CH_STOPPED;
            end
            default: state_d = CH_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // Datapath and programmable fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            os_q    <= 1'b0;
            code_q  <= '0;
            limit_q <= '0;
            count_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ie_q   <= wdata[CTRL_IE_BIT];
                os_q   <= wdata[CTRL_OS_BIT];
                code_q <= wdata[CODE_W-1:0];
            end
            if (limit_we) limit_q <= wdata;
            if (start) begin
                count_q <= '0;
            end else if (tick_eff) begin
                if (match) count_q <= os_q ? count_q : '0;
                else       count_q <= count_q + 1'b1;
            end
            if (match)                   flag_q <= 1'b1;
            else if (flag_we && wdata[0]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[CTRL_IE_BIT]   = ie_q;
        ctrl_rd[CTRL_RUN_BIT]  = (state_q == CH_RUNNING);
        ctrl_rd[CTRL_OS_BIT]   = os_q;
        ctrl_rd[CODE_W-1:0]    = code_q;
        flag_rd                = '0;
        flag_rd[0]             = flag_q;
    end

    assign limit_rd = limit_q;
    assign count_rd = count_q;
    assign irq      = flag_q && ie_q;

    assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOPPED && !ctrl_we) |=> $stable(count_q));

    assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && os_q && !ctrl_we) |=> (state_q == CH_STOPPED && $stable(count_q)));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !os_q && !ctrl_we) |=> (count_q == '0));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == '0 && state_q == CH_RUNNING));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WIN_W = ADDR_W - 7;

    logic [WIN_W-1:0] win;
    logic [6:0]       ofs;
    logic [REG_W-1:0] ctrl_rd  [NUM_CH];
    logic [REG_W-1:0] flag_rd  [NUM_CH];
    logic [REG_W-1:0] limit_rd [NUM_CH];
    logic [REG_W-1:0] count_rd [NUM_CH];

    assign win = bus_addr[ADDR_W-1:7];
    assign ofs = bus_addr[6:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = (win == WIN_W'(g + 1));

        timer_channel #(.W(REG_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (bus_wr && sel && ofs == OFS_CTRL),
            .flag_we  (bus_wr && sel && ofs == OFS_FLAG),
            .limit_we (bus_wr && sel && ofs == OFS_LIMIT),
            .wdata    (bus_wdata),
            .ctrl_rd  (ctrl_rd[g]),
            .flag_rd  (flag_rd[g]),
            .limit_rd (limit_rd[g]),
            .count_rd (count_rd[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (win == WIN_W'(c + 1)) begin
                unique case (ofs)
                    OFS_CTRL:  bus_rdata = ctrl_rd[c];
                    OFS_FLAG:  bus_rdata = flag_rd[c];
                    OFS_LIMIT: bus_rdata = limit_rd[c];
                    OFS_COUNT: bus_rdata = count_rd[c];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int div_of(input int code);
        return (code > 8) ? 256 : (1 << code);
    endfunction

    function automatic int exp_count(input int k, input int d, input int lim, input bit os);
        if (os) return (k < (lim + 1) * d) ? k / d : lim;
        return (k / d) % (lim + 1);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        #45 rst_n = 1'b1;

        // R12 reset state
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                rd(9'(9'h080 * (c + 1) + r * 4), v);
                chk("R12", v, 16'h0000);
            end
        end
        chk("R12 irq", {14'b0, irq}, 16'h0000);

        // R1 unmapped and limit readback
        rd(9'h004, v); chk("R1 unmapped", v, 16'h0000);
        rd(9'h090, v); chk("R1 unmapped ofs", v, 16'h0000);
        wr(9'h108, 16'hA5C3);
        rd(9'h108, v); chk("R1 limit readback", v, 16'hA5C3);

        // R2 field layout, R10 independence
        wr(9'h100, 16'hFFFF);
        rd(9'h100, v); chk("R2 ctrl mask", v, 16'h013F);
        wait_cyc(20);
        rd(9'h08C, v); chk("R10 ch0 untouched", v, 16'h0000);
        rd(9'h080, v); chk("R10 ch0 ctrl", v, 16'h0000);
        wr(9'h100, 16'h0000);

        // R11 limit written while stopped, R4 match timing
        wr(9'h088, 16'd3);
        wr(9'h080, 16'h0020);
        wait_cyc(3);
        rd(9'h084, v); chk("R11 no flag before match", v, 16'h0000);
        rd(9'h084, v); chk("R11 flag at limit+1 ticks", v, 16'h0001);
        rd(9'h08C, v); chk("R4 wrapped count", v, 16'd1);

        // R6 stop freezes count
        wr(9'h080, 16'h0000); wr(9'h084, 16'h0001);
        wr(9'h088, 16'd100);
        wr(9'h080, 16'h0021);
        wait_cyc(9);
        wr(9'h080, 16'h0001);
        rd(9'h08C, v); chk("R6 count at stop", v, 16'd4);
        wait_cyc(5);
        rd(9'h08C, v); chk("R6 count held", v, 16'd4);
        rd(9'h080, v); chk("R6 run bit clear", v, 16'h0001);

        // R7 restart from stopped, and rewrite while running
        wr(9'h080, 16'h0021);
        rd(9'h08C, v); chk("R7 count zero on start", v, 16'd0);
        wait_cyc(3);
        rd(9'h08C, v); chk("R7 count after restart", v, 16'd1);
        wr(9'h080, 16'h0021);
        rd(9'h08C, v); chk("R7 no restart while running", v, 16'd2);
        wr(9'h080, 16'h0000);

        // R8 flag clear semantics, R9 gating
        wr(9'h088, 16'd0);
        wr(9'h080, 16'h0020);
        wait_cyc(2);
        wr(9'h080, 16'h0000);
        rd(9'h084, v); chk("R8 flag set", v, 16'h0001);
        chk("R9 irq masked", {14'b0, irq}, 16'h0000);
        wr(9'h080, 16'h0100);
        rd(9'h084, v); chk("R9 irq enabled", {14'b0, irq}, 16'h0001);
        wr(9'h084, 16'h0000);
        rd(9'h084, v); chk("R8 write 0 ignored", v, 16'h0001);
        wr(9'h084, 16'h0001);
        rd(9'h084, v); chk("R8 write 1 clears", v, 16'h0000);
        chk("R9 irq drops", {14'b0, irq}, 16'h0000);
        wr(9'h080, 16'h0000);

        // R5 single-run directed
        wr(9'h108, 16'd2);
        wr(9'h100, 16'h0030);
        wait_cyc(10);
        rd(9'h10C, v); chk("R5 count held at limit", v, 16'd2);
        rd(9'h100, v); chk("R5 run bit cleared", v, 16'h0010);
        wr(9'h104, 16'h0001);

        // R13 full 16-bit wrap
        wr(9'h108, 16'hFFFF);
        wr(9'h100, 16'h0020);
        wait_cyc(65539);
        rd(9'h10C, v); chk("R13 full wrap", v, 16'd3);
        rd(9'h104, v); chk("R13 flag on wrap", v, 16'h0001);
        wr(9'h100, 16'h0000); wr(9'h104, 16'h0001);

        // R3 R4 R5 constrained random
        for (int it = 0; it < 24; it++) begin
            int ch = int'($urandom % 2);
            logic [8:0] base = ch ? 9'h100 : 9'h080;
            int code = int'($urandom % 11);
            int lim = int'($urandom % 12);
            bit os = 1'($urandom % 2);
            int d = div_of(code);
            int k = int'($urandom % (2 * (lim + 1) * d + 4));
            int per = (lim + 1) * d;
            wr(base, 16'h0000);
            wr(9'(base + 4), 16'h0001);
            wr(9'(base + 8), 16'(lim));
            wr(base, 16'h0120 | (16'(os) << 4) | 16'(code));
            wait_cyc(k);
            rd(9'(base + 12), v);
            chk("R3 random count", v, 16'(exp_count(k, d, lim, os)));
            rd(9'(base + 4), v);
            chk("R4 random flag", v, 16'((k + 1) >= per));
            chk("R9 random irq", 16'(irq[ch]), 16'((k + 1) >= per));
            rd(base, v);
            chk("R5 random ctrl", v, 16'h0100 | (16'(os) << 4) | 16'(code) |
                ((os && (k + 2) >= per) ? 16'h0000 : 16'h0020));
            wr(base, 16'h0000);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule